// File: doc/BRIEF.md
# Multiplexed-Bus CPU Port with TDM Arbitration

This block is the host-processor port of a time-division switching device. A host CPU reaches it over an 8-bit bus that carries the address first and then the data. The address is captured while the latch strobe is high. After that a data phase begins, and it is decoded either into a small register file or into a paged window onto four internal memories.

The memories are also used by the TDM stream engines, which own fixed cycles. A CPU memory access therefore waits for a free cycle, and its completion is reported through an acknowledge output after a variable delay. If the TDM clocks stop, the acknowledge is held off until they return.

Four timing-error indications feed sticky status bits. Each bit has its own mask, and the unmasked bits drive an active-high interrupt.

Top module: `cpu_port_arb`

## Requirements
- R1: The address is latched from `ad_in` while `ale` is high. If latched bit 7 is 0, the access goes to a register, with bits 6..0 as the register number. The register numbers are:
  - 0: control. Bits 4..0 hold the page and bits 7..5 hold the memory select.
  - 1: status.
  - 2: mask.
  - 3 and 4 (and up to N_CFG registers from 3): plain configuration registers, each visible on `cfg_out` at byte index n-3.
- R2: Intel-style cycles work. With `cs_n` low, a falling `rd_ds_n` starts a read, and a falling `wr_rw` (while `rd_ds_n` is high) starts a write. The phase ends when that same line rises or `cs_n` rises. Write data is taken from `ad_in` in the cycle the falling edge is first seen.
- R3: Motorola-style cycles work on the same pins with no mode input. `wr_rw` is a level set before `cs_n` falls (1 = read, 0 = write), and a falling `rd_ds_n` starts the phase. The phase ends when `rd_ds_n` or `cs_n` rises.
- R4: A register access raises `ack` one clock after the strobe edge is seen. `ack` stays high until the phase ends. During a read, while `ack` is high, `ad_oe` is 1 and `ad_out` carries the data.
- R5: If latched bit 7 is 1, the memory address is {page, bits 6..0}. The memory select codes are:
  - 0: transmit connection memory.
  - 1: transmit data memory.
  - 2: receive connection memory.
  - 3: receive data memory.
  - 4 to 7: no memory. Reads return 0, and `mem_en` stays low.
- R6: Connection memories (`mem_id` 0 and 2) can be read and written. A write aimed at a data memory (`mem_id` 1 or 3) never raises `mem_we`, but it is still acknowledged.
- R7: The TDM side owns every cycle flagged by `tdm_turn`. `mem_en` is asserted only in a CPU cycle, and that cycle is one in every SLOT_PERIOD clocks. `ack` follows the granted cycle once the returned data has been captured.
- R8: While `tdm_clk_ok` is 0, no memory cycle is granted and a pending memory access keeps `ack` low. Once the clocks return, the access completes.
- R9: Each status bit is set by a one-cycle high on its `err_in` bit and stays set. Writing 1 to a bit of the status register clears it. A new error in the same cycle as the clear wins.
- R10: `irq` is the OR of the status bits whose mask bit is 0. A masked error still sets its status bit.
- R11: Reading an unmapped register number returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus inputs are sampled synchronously |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch / address strobe, active high |
| rd_ds_n | input | 1 | Read strobe (Intel) or data strobe (Motorola), active low |
| wr_rw | input | 1 | Write strobe (Intel) or read/not-write level (Motorola) |
| ad_in | input | 8 | Multiplexed address/data in |
| ad_out | output | 8 | Read data out |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ack | output | 1 | Data acknowledge |
| err_in | input | N_ERR | Timing-error indication pulses |
| irq | output | 1 | Interrupt request, active high |
| cfg_out | output | N_CFG*8 | Configuration register contents |
| tdm_clk_ok | input | 1 | TDM clocks present |
| tdm_turn | output | 1 | This cycle belongs to the TDM engines |
| mem_en | output | 1 | CPU memory cycle |
| mem_we | output | 1 | CPU memory write |
| mem_id | output | 2 | Memory select for the CPU cycle |
| mem_addr | output | PAGE_W+7 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one clock after `mem_en` |

## Verification
The in-line properties check several rules on every clock:
- A CPU memory cycle never lands in a TDM-owned cycle or while the TDM clocks are absent.
- `mem_we` never names a data memory.
- A register access is acknowledged on the next clock.
- `ack` falls once chip select is released.
- A new error survives a simultaneous clear.
- The interrupt only rises after an error or a register write.

Only the bench scenarios can show the following:
- Both bus styles share the pins correctly.
- The page and select fields compose the right memory address.
- Data written to a connection memory reads back, while a write to a data memory leaves its contents intact.
- A stopped TDM clock holds the acknowledge off for an arbitrary time.
- Masking changes the interrupt but not the status bits.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE,
      ACC_WAIT,
      ACC_CAPT,
      ACC_DONE
   } acc_state_t;

   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_STAT = 1;
   localparam int unsigned REG_MASK = 2;
   localparam int unsigned REG_CFG0 = 3;
   localparam int unsigned N_MEM    = 4;
endpackage

// File: rtl/cpu_bus_front.sv
// Bus-style inference, address latch and data-phase tracking.
module cpu_bus_front #(
   parameter int unsigned BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             ale,
   input  logic             rd_ds_n,
   input  logic             wr_rw,
   input  logic [BUS_W-1:0] ad_in,
   output logic [BUS_W-1:0] addr_q,
   output logic             start,
   output logic             start_wr,
   output logic             active,
   output logic             stop
);
   logic rd_q, wr_q, use_wr_q;
   logic rd_fall, wr_fall;

   generate
      if (BUS_W < 8) begin : g_bad_bus
         $error("cpu_bus_front: BUS_W must be at least 8");
      end
   endgenerate

   always_comb begin
      rd_fall  = rd_q & ~rd_ds_n;
      // a falling write line only opens a phase while the read/data strobe is idle
      wr_fall  = wr_q & ~wr_rw & rd_ds_n;
      start    = ~active & ~cs_n & (rd_fall | wr_fall);
      start_wr = ~wr_rw;
      stop     = active & (cs_n | (use_wr_q ? wr_rw : rd_ds_n));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q     <= 1'b1;
         wr_q     <= 1'b1;
         use_wr_q <= 1'b0;
         active   <= 1'b0;
         addr_q   <= '0;
      end else begin
         rd_q <= rd_ds_n;
         wr_q <= wr_rw;
         if (ale) addr_q <= ad_in;
         if (start) begin
            active   <= 1'b1;
            use_wr_q <= wr_fall;
         end else if (stop) begin
            active <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cpu_port_regs.sv
// Control, status, mask and configuration registers with interrupt.
module cpu_port_regs
   import cpu_port_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PAGE_W = 5,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned N_ERR  = 4,
   parameter int unsigned N_CFG  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [N_ERR-1:0]        err_in,
   output logic [DATA_W-1:0]       rdata,
   output logic [PAGE_W-1:0]       page,
   output logic [SEL_W-1:0]        sel,
   output logic                    irq,
   output logic [N_CFG*DATA_W-1:0] cfg_out
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(REG_MASK);

   generate
      if (PAGE_W + SEL_W != DATA_W) begin : g_bad_ctrl
         $error("cpu_port_regs: page and select must fill one register");
      end
      if (N_ERR >= DATA_W) begin : g_bad_err
         $error("cpu_port_regs: N_ERR must be below DATA_W");
      end
      if (REG_CFG0 + N_CFG > (1 << ADDR_W)) begin : g_bad_cfg
         $error("cpu_port_regs: too many configuration registers");
      end
   endgenerate

   logic [DATA_W-1:0]       ctrl_q;
   logic [N_ERR-1:0]        mask_q, stat_q, stat_d, stat_clr;
   logic [N_CFG*DATA_W-1:0] cfg_q;

   assign stat_clr = (wr_en && addr == A_STAT) ? wdata[N_ERR-1:0] : '0;

   genvar gi;
   generate
      for (gi = 0; gi < N_ERR; gi++) begin : g_stat
         // a fresh error beats a clear in the same cycle
         assign stat_d[gi] = err_in[gi] | (stat_q[gi] & ~stat_clr[gi]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= '0;
         stat_q <= '0;
         cfg_q  <= '0;
      end else begin
         stat_q <= stat_d;
         if (wr_en && addr == A_CTRL) ctrl_q <= wdata;
         if (wr_en && addr == A_MASK) mask_q <= wdata[N_ERR-1:0];
         for (int i = 0; i < N_CFG; i++) begin
            if (wr_en && addr == ADDR_W'(REG_CFG0 + i))
               cfg_q[i*DATA_W +: DATA_W] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_CTRL) rdata = ctrl_q;
      if (addr == A_STAT) rdata = {{(DATA_W-N_ERR){1'b0}}, stat_q};
      if (addr == A_MASK) rdata = {{(DATA_W-N_ERR){1'b0}}, mask_q};
      for (int i = 0; i < N_CFG; i++) begin
         if (addr == ADDR_W'(REG_CFG0 + i)) rdata = cfg_q[i*DATA_W +: DATA_W];
      end
   end

   assign page    = ctrl_q[PAGE_W-1:0];
   assign sel     = ctrl_q[PAGE_W +: SEL_W];
   assign irq     = |(stat_q & ~mask_q);
   assign cfg_out = cfg_q;

   // R9: an error seen this cycle is recorded even when a clear coincides
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_in) |=> ((stat_q & $past(err_in)) == $past(err_in)));

   // R10: the interrupt only rises after an error pulse or a register write
   p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past((|err_in) || wr_en));
endmodule

// File: rtl/cpu_mem_arb.sv
// Fixed-slot arbiter sharing the memory port between TDM and CPU.
module cpu_mem_arb #(
   parameter int unsigned SLOT_PERIOD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_ok,
   input  logic req,
   output logic grant,
   output logic tdm_turn
);
   localparam int unsigned CW = (SLOT_PERIOD > 1) ? $clog2(SLOT_PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(SLOT_PERIOD - 1);

   generate
      if (SLOT_PERIOD < 2) begin : g_bad_period
         $error("cpu_mem_arb: TDM needs at least one slot per period");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          cpu_slot;

   generate
      if ((SLOT_PERIOD & (SLOT_PERIOD - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt <= '0;
            else if (clk_ok) cnt <= cnt + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt <= '0;
            else if (clk_ok) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
      end
   endgenerate

   assign cpu_slot = clk_ok && (cnt == LAST);
   assign grant    = req && cpu_slot;
   assign tdm_turn = clk_ok && (cnt != LAST);

   // R7: a CPU cycle is always followed by a TDM cycle while clocks run
   p_tdm_after_cpu_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_slot |=> (!clk_ok || tdm_turn));

   // R8: the slot sequence freezes while the TDM clocks are absent
   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_ok |=> $stable(cnt));
endmodule

// File: rtl/cpu_port_arb.sv
// Top: multiplexed CPU port, register file, memory window and arbitration.
module cpu_port_arb
   import cpu_port_pkg::*;
#(
   parameter int unsigned BUS_W       = 8,
   parameter int unsigned PAGE_W      = 5,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned N_ERR       = 4,
   parameter int unsigned N_CFG       = 3,
   parameter int unsigned SLOT_PERIOD = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   ale,
   input  logic                   rd_ds_n,
   input  logic                   wr_rw,
   input  logic [BUS_W-1:0]       ad_in,
   output logic [BUS_W-1:0]       ad_out,
   output logic                   ad_oe,
   output logic                   ack,
   input  logic [N_ERR-1:0]       err_in,
   output logic                   irq,
   output logic [N_CFG*BUS_W-1:0] cfg_out,
   input  logic                   tdm_clk_ok,
   output logic                   tdm_turn,
   output logic                   mem_en,
   output logic                   mem_we,
   output logic [1:0]             mem_id,
   output logic [PAGE_W+BUS_W-2:0] mem_addr,
   output logic [BUS_W-1:0]       mem_wdata,
   input  logic [BUS_W-1:0]       mem_rdata
);
   localparam int unsigned LO_W    = BUS_W - 1;
   localparam int unsigned MADDR_W = PAGE_W + LO_W;
   localparam int unsigned MID_W   = $clog2(N_MEM);

   generate
      if (MID_W != 2) begin : g_bad_mid
         $error("cpu_port_arb: memory id port is two bits wide");
      end
   endgenerate

   logic [BUS_W-1:0]   addr_q, reg_rdata, rdata_q, wdata_q;
   logic               start, start_wr, active, stop;
   logic [PAGE_W-1:0]  page;
   logic [SEL_W-1:0]   sel;
   logic               mem_hit, reg_wr, req, grant;
   logic               acc_wr;
   logic [MID_W-1:0]   acc_id;
   logic [MADDR_W-1:0] acc_addr;
   acc_state_t         st;

   cpu_bus_front #(.BUS_W(BUS_W)) u_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ale(ale), .rd_ds_n(rd_ds_n),
      .wr_rw(wr_rw), .ad_in(ad_in), .addr_q(addr_q), .start(start),
      .start_wr(start_wr), .active(active), .stop(stop)
   );

   assign reg_wr = start && !addr_q[BUS_W-1] && start_wr;

   cpu_port_regs #(
      .ADDR_W(LO_W), .DATA_W(BUS_W), .PAGE_W(PAGE_W), .SEL_W(SEL_W),
      .N_ERR(N_ERR), .N_CFG(N_CFG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(addr_q[LO_W-1:0]),
      .wdata(ad_in), .err_in(err_in), .rdata(reg_rdata), .page(page),
      .sel(sel), .irq(irq), .cfg_out(cfg_out)
   );

   assign req = (st == ACC_WAIT) && !stop;

   cpu_mem_arb #(.SLOT_PERIOD(SLOT_PERIOD)) u_arb (
      .clk(clk), .rst_n(rst_n), .clk_ok(tdm_clk_ok), .req(req),
      .grant(grant), .tdm_turn(tdm_turn)
   );

   assign mem_hit = (sel < SEL_W'(N_MEM));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ACC_IDLE;
         acc_wr   <= 1'b0;
         acc_id   <= '0;
         acc_addr <= '0;
         rdata_q  <= '0;
         wdata_q  <= '0;
      end else begin
         unique case (st)
            ACC_IDLE: if (start) begin
               acc_wr  <= start_wr;
               wdata_q <= ad_in;
               if (!addr_q[BUS_W-1]) begin
                  rdata_q <= reg_rdata;
                  st      <= ACC_DONE;
               end else if (!mem_hit) begin
                  rdata_q <= '0;
                  st      <= ACC_DONE;
               end else begin
                  acc_addr <= {page, addr_q[LO_W-1:0]};
                  acc_id   <= sel[MID_W-1:0];
                  st       <= ACC_WAIT;
               end
            end
            ACC_WAIT: begin
               if (stop)       st <= ACC_IDLE;
               else if (grant) st <= ACC_CAPT;
            end
            ACC_CAPT: begin
               if (stop) st <= ACC_IDLE;
               else begin
                  rdata_q <= mem_rdata;
                  st      <= ACC_DONE;
               end
            end
            ACC_DONE: if (stop) st <= ACC_IDLE;
            default:  st <= ACC_IDLE;
         endcase
      end
   end

   assign ack       = (st == ACC_DONE);
   assign ad_oe     = ack && !acc_wr;
   assign ad_out    = rdata_q;
   assign mem_en    = grant;
   // odd ids are the read-only data memories
   assign mem_we    = grant && acc_wr && !acc_id[0];
   assign mem_id    = acc_id;
   assign mem_addr  = acc_addr;
   assign mem_wdata = wdata_q;

   // R4: a register access is acknowledged on the following clock
   p_reg_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ACC_IDLE && start && !addr_q[BUS_W-1]) |=> ack);

   // R4: releasing chip select withdraws the acknowledge
   p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && cs_n) |=> !ack);

   // R6: data memories never see a write strobe
   p_dmem_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !mem_id[0]);

   // R7 and R8: CPU memory cycles avoid TDM slots and stopped clocks
   p_mem_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (!tdm_turn && tdm_clk_ok));
endmodule

// File: tb/test_cpu_port_arb.sv
`timescale 1ns/1ps
module test_cpu_port_arb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, ale = 1'b0, rd_ds_n = 1'b1, wr_rw = 1'b1;
   logic [7:0]  ad_in = '0;
   logic [7:0]  ad_out;
   logic        ad_oe, ack, irq;
   logic [3:0]  err_in = '0;
   logic [23:0] cfg_out;
   logic        tdm_clk_ok = 1'b1;
   logic        tdm_turn, mem_en, mem_we;
   logic [1:0]  mem_id;
   logic [11:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   int checks = 0, failures = 0;
   int slot_err = 0, ro_err = 0;
   logic [11:0] last_waddr = '0;
   bit done = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] cmem0 [int];
   logic [7:0] cmem2 [int];
   logic       ack_prev = 1'b0;

   always #4 clk = ~clk;

   cpu_port_arb i_cpu_port_arb (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ale(ale), .rd_ds_n(rd_ds_n),
      .wr_rw(wr_rw), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .ack(ack),
      .err_in(err_in), .irq(irq), .cfg_out(cfg_out), .tdm_clk_ok(tdm_clk_ok),
      .tdm_turn(tdm_turn), .mem_en(mem_en), .mem_we(mem_we), .mem_id(mem_id),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] dmem_val(input logic [1:0] id, input logic [11:0] a);
      return a[7:0] ^ ((id == 2'd1) ? 8'h3C : 8'hC3);
   endfunction

   // memory model: read data one clock after the enable
   always @(posedge clk) begin
      if (mem_en) begin
         case (mem_id)
            2'd0: begin
               mem_rdata <= cmem0.exists(int'(mem_addr)) ? cmem0[int'(mem_addr)] : 8'h00;
               if (mem_we) cmem0[int'(mem_addr)] = mem_wdata;
            end
            2'd2: begin
               mem_rdata <= cmem2.exists(int'(mem_addr)) ? cmem2[int'(mem_addr)] : 8'h00;
               if (mem_we) cmem2[int'(mem_addr)] = mem_wdata;
            end
            default: mem_rdata <= dmem_val(mem_id, mem_addr);
         endcase
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected byte per acknowledged read
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_en && tdm_turn) slot_err++;
         if (mem_we && mem_id[0]) ro_err++;
         if (mem_en && mem_we) last_waddr = mem_addr;
         if (ack && ad_oe && !ack_prev) begin
            if (exp_q.size() == 0) chk(0, "unexpected read data", int'(ad_out), 0);
            else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(ad_out == e, t, int'(ad_out), int'(e));
            end
         end
      end
      ack_prev = ack;
   end

   task automatic bus_cycle(input bit moto, input bit wr, input logic [7:0] a,
                            input logic [7:0] d, input logic [3:0] ep, output int lat);
      @(negedge clk);
      ad_in = a; ale = 1'b1;
      if (moto) wr_rw = !wr;
      @(negedge clk);
      ale = 1'b0; cs_n = 1'b0;
      @(negedge clk);
      if (wr) ad_in = d;
      err_in = ep;
      if (moto || !wr) rd_ds_n = 1'b0;
      else wr_rw = 1'b0;
      lat = 0;
      do begin
         @(negedge clk);
         err_in = '0;
         lat++;
      end while (!ack && lat < 300);
      rd_ds_n = 1'b1;
      if (!moto) wr_rw = 1'b1;
      @(negedge clk);
      cs_n = 1'b1; wr_rw = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_wr(input bit moto, input logic [7:0] a, input logic [7:0] d,
                        input logic [3:0] ep, input string tag);
      int lat;
      bus_cycle(moto, 1'b1, a, d, ep, lat);
      chk(lat < 300, {tag, " write ack"}, lat, 0);
   endtask

   task automatic do_rd(input bit moto, input logic [7:0] a, input logic [7:0] e,
                        input int exp_lat, input string tag);
      int lat;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      bus_cycle(moto, 1'b0, a, 8'h00, 4'h0, lat);
      if (exp_lat > 0) chk(lat == exp_lat, {tag, " ack latency"}, lat, exp_lat);
      else chk(lat < 300, {tag, " ack seen"}, lat, 0);
   endtask

   task automatic pulse_err(input logic [3:0] v);
      @(negedge clk); err_in = v;
      @(negedge clk); err_in = '0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4 R10: reset state
      chk(!ack && !ad_oe && !irq && !mem_en, "R4 R10 reset outputs", {ack, ad_oe, irq, mem_en}, 0);

      // R1 R2 R3 R4: control register through both bus styles
      do_wr(0, 8'h00, 8'h03, 4'h0, "R2 intel ctrl");
      do_rd(1, 8'h00, 8'h03, 1, "R3 R4 moto read ctrl");
      do_wr(0, 8'h03, 8'hA5, 4'h0, "R2 intel cfg0");
      do_wr(1, 8'h04, 8'h5A, 4'h0, "R3 moto cfg1");
      chk(cfg_out[7:0] == 8'hA5, "R1 cfg0 output", cfg_out[7:0], 8'hA5);
      chk(cfg_out[15:8] == 8'h5A, "R1 cfg1 output", cfg_out[15:8], 8'h5A);
      do_rd(0, 8'h04, 8'h5A, 1, "R2 R4 intel read cfg1");
      do_rd(0, 8'h7F, 8'h00, 1, "R11 unmapped reg");

      // R5 R6: transmit connection memory, page 3
      do_wr(0, 8'h95, 8'h77, 4'h0, "R6 tx conn write");
      chk(last_waddr == 12'h195, "R5 composed address", last_waddr, 12'h195);
      do_rd(1, 8'h95, 8'h77, 0, "R6 tx conn readback");

      // R5 R6: receive connection memory, page 0x1F
      do_wr(1, 8'h00, 8'h5F, 4'h0, "R3 ctrl sel2");
      do_wr(1, 8'hA2, 8'h3E, 4'h0, "R6 rx conn write");
      chk(last_waddr == 12'hFA2, "R5 rx address", last_waddr, 12'hFA2);
      do_rd(0, 8'hA2, 8'h3E, 0, "R6 rx conn readback");

      // R6: data memory is read-only
      do_wr(0, 8'h00, 8'h23, 4'h0, "R2 ctrl sel1");
      do_rd(0, 8'h95, dmem_val(2'd1, 12'h195), 0, "R6 tx data read");
      do_wr(0, 8'h95, 8'hEE, 4'h0, "R6 tx data write");
      do_rd(1, 8'h95, dmem_val(2'd1, 12'h195), 0, "R6 tx data unchanged");

      // R5: unmapped select returns zero
      do_wr(0, 8'h00, 8'hA0, 4'h0, "R2 ctrl sel5");
      do_rd(0, 8'h95, 8'h00, 0, "R5 unmapped select read");

      // R8: stopped TDM clocks hold the acknowledge
      do_wr(0, 8'h00, 8'h03, 4'h0, "R2 ctrl back to sel0");
      tdm_clk_ok = 1'b0;
      fork
         do_rd(0, 8'h95, 8'h77, 0, "R8 read after clocks return");
         begin
            repeat (40) @(negedge clk);
            chk(!ack, "R8 ack held without clocks", ack, 0);
            tdm_clk_ok = 1'b1;
         end
      join

      // R9 R10: sticky status, write-one-to-clear, masking
      pulse_err(4'b0101);
      chk(irq, "R10 irq after unmasked error", irq, 1);
      do_rd(0, 8'h01, 8'h05, 1, "R9 status sticky");
      do_wr(0, 8'h01, 8'h01, 4'h0, "R9 clear bit0");
      do_rd(1, 8'h01, 8'h04, 1, "R9 status after clear");
      chk(irq, "R10 irq still from bit2", irq, 1);
      do_wr(0, 8'h01, 8'h04, 4'h0, "R9 clear bit2");
      chk(!irq, "R10 irq low when clear", irq, 0);
      do_wr(0, 8'h02, 8'h02, 4'h0, "R10 mask bit1");
      pulse_err(4'b0010);
      chk(!irq, "R10 masked error no irq", irq, 0);
      do_rd(0, 8'h01, 8'h02, 1, "R10 masked error recorded");
      do_wr(1, 8'h02, 8'h00, 4'h0, "R10 unmask");
      chk(irq, "R10 irq after unmask", irq, 1);
      do_wr(0, 8'h01, 8'h02, 4'h0, "R9 clear bit1");
      pulse_err(4'b0001);
      do_wr(0, 8'h01, 8'h01, 4'b0001, "R9 clear with new error");
      do_rd(0, 8'h01, 8'h01, 1, "R9 set wins over clear");

      // R6 R7: port-level arbitration and read-only observations
      chk(slot_err == 0, "R7 no cpu cycle in tdm slot", slot_err, 0);
      chk(ro_err == 0, "R6 no write strobe to data memory", ro_err, 0);
      chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule